// File: doc/BRIEF.md
# Write-Protected Timekeeping Byte Store

This block is a byte-wide scratch memory whose highest eight bytes are a real-time clock register set. It holds seven BCD time counters: seconds, minutes, hours, day of week, day of month, month and a two-digit year. A once-per-second `tick` pulse advances them. A test port can load all seven counters in one cycle.

Every memory write has to be paired with an earlier write to a separate unlock register. That unlock write grants exactly one memory write. After that one write, permission is withdrawn again. Writes made without permission leave the memory unchanged.

One control byte, just below the clock bytes, holds a freeze bit. While the freeze bit is clear, reads of the clock bytes return the live counters. When a permitted write sets the freeze bit, the counters are copied into the clock bytes, and from then on reads return that frozen copy.

The memory port follows valid/ready rules. `mem_ready` is held high, so a request is taken in every cycle in which `mem_valid` is high. A read answers exactly one cycle later with `mem_rvalid`. The read response has no back-pressure: the requester must be able to take it. The unlock, tick and load pins are plain level or pulse controls.

Top module: `tk_nvram`

## Requirements
- R1: After reset, the write permission is cleared and `mem_rvalid` is 0. The counters hold 00:00:00, day of week 1, day 1 of month 1, year 00. Memory bytes keep their contents across reset.
- R2: A cycle with `unlk_wr` high arms write permission. `unlk_state` reads 1 while armed and 0 otherwise; bits 31..1 are always 0.
- R3: While armed, a memory write (`mem_valid` and `mem_we` high) is stored and then clears the permission. A second write that has no new unlock is not stored.
- R4: A memory write made while not armed leaves the addressed byte unchanged.
- R5: `mem_ready` is always 1. A read taken in cycle t gives `mem_rvalid` high with `mem_rdata` in cycle t+1. Addresses 0x000 to 0x7F8 return the stored byte.
- R6: While bit 6 of the control byte at 0x7F8 is 0, reads of the clock bytes return the live counters, one counter per address:
  - 0x7F9 seconds
  - 0x7FA minutes
  - 0x7FB hours
  - 0x7FC day of week
  - 0x7FD day of month
  - 0x7FE month
  - 0x7FF year
- R7: A permitted write of a value with bit 6 set to 0x7F8 copies the counters into 0x7F9 to 0x7FF. While bit 6 stays set, reads return that copy and ignore later ticks. Permitted writes to those addresses change the copy.
- R8: Each `tick` advances the time in packed BCD. Seconds and minutes wrap from 59 to 00 and carry. Hours wrap from 23 to 00 (24-hour format) and carry into the day.
- R9: On a day change, day of week steps up by one, and 7 wraps to 1.
- R10: On a day change, day of month returns to 01 after the last day of the month. Months 4, 6, 9 and 11 have 30 days; February has 29 days when the BCD year is a multiple of 4 (00 included) and 28 otherwise; all other months have 31. Month 12 wraps to 01 and carries into the year, and year 99 wraps to 00.
- R11: A cycle with `tload_en` high loads the counters from `tload_tod`, laid out {year, month, day, weekday, hour, minute, second}. The load takes priority over `tick` in the same cycle. With neither input high, the counters hold.
- R12: When `unlk_wr` and a memory write fall in the same cycle, the write is judged against the permission held before that cycle. The block is armed afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_valid | input | 1 | Memory request valid |
| mem_ready | output | 1 | Memory request ready (always 1) |
| mem_we | input | 1 | 1 = write, 0 = read |
| mem_addr | input | 11 | Byte address |
| mem_wdata | input | 8 | Write byte |
| mem_rvalid | output | 1 | Read data valid |
| mem_rdata | output | 8 | Read byte |
| unlk_wr | input | 1 | Unlock register write strobe |
| unlk_state | output | 32 | Unlock register read value (bit 0 = armed) |
| tick | input | 1 | One-second advance pulse |
| tload_en | input | 1 | Load counters |
| tload_tod | input | 56 | Time to load, BCD bytes |

## Verification
The bench builds the block with its default 11-bit address. That gives the full 2048-byte space, with the clock bytes at the very top and the control byte at 0x7F8. Loading times just before a minute, hour, day, month-end, leap-day and century-of-year boundary puts every carry path within a few ticks. Random loads and random tick runs then cover ordinary days. Random armed and unarmed writes and reads in the low memory are checked against a byte model. The freeze copy, same-cycle unlock with write, and load-beats-tick cases are driven directly.

// File: rtl/tk_pkg.sv
package tk_pkg;

  typedef struct packed {
    logic [7:0] yr;
    logic [7:0] mon;
    logic [7:0] mday;
    logic [7:0] wday;
    logic [7:0] hr;
    logic [7:0] min;
    logic [7:0] sec;
  } tod_t;

  localparam int TOD_BYTES = 7;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic is_leap(input logic [7:0] y);
    if (!y[4]) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
  endfunction

  function automatic logic [7:0] last_day(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02: return is_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/tk_unlock.sv
module tk_unlock (
  input  logic clk,
  input  logic rst_n,
  input  logic unlk_wr,
  input  logic wr_req,
  output logic armed
);

  always_ff @(posedge clk) begin
    if (!rst_n)       armed <= 1'b0;
    else if (unlk_wr) armed <= 1'b1;
    else if (wr_req)  armed <= 1'b0;
  end

  // R2
  arm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unlk_wr |=> armed);

  // R3
  arm_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && wr_req && !unlk_wr) |=> !armed);

endmodule

// File: rtl/tk_clock.sv
module tk_clock
  import tk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic load,
  input  tod_t load_tod,
  output tod_t tod
);

  tod_t nxt;
  logic sec_w, min_w, hr_w, day_end, mon_w, day_c;

  always_comb begin
    sec_w   = (tod.sec == 8'h59);
    min_w   = (tod.min == 8'h59);
    hr_w    = (tod.hr  == 8'h23);
    day_end = (tod.mday == last_day(tod.mon, tod.yr));
    mon_w   = (tod.mon == 8'h12);
    day_c   = sec_w && min_w && hr_w;
    nxt     = tod;
    nxt.sec = sec_w ? 8'h00 : bcd_inc(tod.sec);
    if (sec_w) nxt.min = min_w ? 8'h00 : bcd_inc(tod.min);
    if (sec_w && min_w) nxt.hr = hr_w ? 8'h00 : bcd_inc(tod.hr);
    if (day_c) begin
      nxt.wday = (tod.wday == 8'h07) ? 8'h01 : bcd_inc(tod.wday);
      nxt.mday = day_end ? 8'h01 : bcd_inc(tod.mday);
      if (day_end) begin
        nxt.mon = mon_w ? 8'h01 : bcd_inc(tod.mon);
        if (mon_w) nxt.yr = (tod.yr == 8'h99) ? 8'h00 : bcd_inc(tod.yr);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    tod <= '{yr: 8'h00, mon: 8'h01, mday: 8'h01, wday: 8'h01,
                           hr: 8'h00, min: 8'h00, sec: 8'h00};
    else if (load) tod <= load_tod;
    else if (tick) tod <= nxt;
  end

  // R8
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && tod.sec == 8'h59) |=> (tod.sec == 8'h00));

  // R9
  wday_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && tod.wday == 8'h07 && tod.hr == 8'h23 &&
     tod.min == 8'h59 && tod.sec == 8'h59) |=> (tod.wday == 8'h01));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(tod));

  // R11
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (tod == $past(load_tod)));

endmodule

// File: rtl/tk_store.sv
module tk_store
  import tk_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int FREEZE_BIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic              rd_req,
  input  logic              armed,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  tod_t              live,
  output logic              rvalid,
  output logic [7:0]        rdata
);

  localparam int DEPTH    = 1 << ADDR_W;
  localparam int CTRL_IDX = DEPTH - 8;

  logic [7:0] mem [DEPTH];
  logic       frozen, in_clk, wr_ok, capture;
  logic [2:0] off;
  logic [7:0] live_b;

  assign frozen  = mem[CTRL_IDX][FREEZE_BIT];
  assign off     = addr[2:0];
  assign in_clk  = (addr[ADDR_W-1:3] == {(ADDR_W-3){1'b1}}) && (off != 3'd0);
  assign wr_ok   = wr_req && armed;
  assign capture = wr_ok && (int'(addr) == CTRL_IDX) && wdata[FREEZE_BIT];

  always_comb begin
    live_b = 8'h00;
    for (int k = 1; k <= TOD_BYTES; k++)
      if (int'(off) == k) live_b = live[(k-1)*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[addr] <= wdata;
    if (capture)
      for (int k = 1; k <= TOD_BYTES; k++) mem[CTRL_IDX + k] <= live[(k-1)*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rvalid <= 1'b0;
    else        rvalid <= rd_req;
  end

  always_ff @(posedge clk) begin
    if (rd_req) rdata <= (in_clk && !frozen) ? live_b : mem[addr];
  end

  // R5
  rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rvalid);

  // R5
  no_spur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rvalid);

  // R4
  locked_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !armed && int'(addr) < CTRL_IDX) |=> (mem[$past(addr)] == $past(mem[addr])));

  // R3
  open_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && armed) |=> (mem[$past(addr)] == $past(wdata)));

  // R7
  snap_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && frozen && in_clk) |=> (rdata == $past(mem[addr])));

endmodule

// File: rtl/tk_nvram.sv
module tk_nvram
  import tk_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int FREEZE_BIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_valid,
  output logic              mem_ready,
  input  logic              mem_we,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_wdata,
  output logic              mem_rvalid,
  output logic [7:0]        mem_rdata,
  input  logic              unlk_wr,
  output logic [31:0]       unlk_state,
  input  logic              tick,
  input  logic              tload_en,
  input  logic [55:0]       tload_tod
);

  logic wr_req, rd_req, armed;
  tod_t tod;

  assign mem_ready  = 1'b1;
  assign wr_req     = mem_valid && mem_we;
  assign rd_req     = mem_valid && !mem_we;
  assign unlk_state = {31'd0, armed};

  tk_unlock u_unlock (
    .clk(clk), .rst_n(rst_n), .unlk_wr(unlk_wr), .wr_req(wr_req), .armed(armed)
  );

  tk_clock u_clock (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(tload_en),
    .load_tod(tod_t'(tload_tod)), .tod(tod)
  );

  tk_store #(.ADDR_W(ADDR_W), .FREEZE_BIT(FREEZE_BIT)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .rd_req(rd_req), .armed(armed),
    .addr(mem_addr), .wdata(mem_wdata), .live(tod),
    .rvalid(mem_rvalid), .rdata(mem_rdata)
  );

  // R12
  same_cyc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unlk_wr && wr_req) |=> unlk_state[0]);

endmodule

// File: tb/test_tk_nvram.sv
module test_tk_nvram;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mem_valid = 0, mem_we = 0, unlk_wr = 0, tick = 0, tload_en = 0;
  logic [10:0] mem_addr = '0;
  logic [7:0] mem_wdata = '0;
  logic [55:0] tload_tod = '0;
  logic mem_ready, mem_rvalid;
  logic [7:0] mem_rdata;
  logic [31:0] unlk_state;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int ms, mm, mh, mwd, mmd, mmo, my;
  logic [7:0] model [64];
  bit known [64];
  bit armed_m = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tk_nvram i_tk_nvram (
    .clk(clk), .rst_n(rst_n), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .unlk_wr(unlk_wr),
    .unlk_state(unlk_state), .tick(tick), .tload_en(tload_en), .tload_tod(tload_tod)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] i2b(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic int dim(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] exp_clk(input int k);
    case (k)
      1: return i2b(ms);
      2: return i2b(mm);
      3: return i2b(mh);
      4: return i2b(mwd);
      5: return i2b(mmd);
      6: return i2b(mmo);
      default: return i2b(my);
    endcase
  endfunction

  task automatic model_tick();
    ms++;
    if (ms == 60) begin ms = 0; mm++; end
    if (mm == 60) begin mm = 0; mh++; end
    if (mh == 24) begin
      mh = 0;
      mwd = (mwd == 7) ? 1 : mwd + 1;
      mmd++;
      if (mmd > dim(mmo, my)) begin
        mmd = 1; mmo++;
        if (mmo == 13) begin mmo = 1; my = (my + 1) % 100; end
      end
    end
  endtask

  task automatic do_unlock();
    @(negedge clk); unlk_wr = 1;
    @(negedge clk); unlk_wr = 0;
    armed_m = 1;
  endtask

  task automatic do_write(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk); mem_valid = 1; mem_we = 1; mem_addr = a; mem_wdata = d;
    @(negedge clk); mem_valid = 0; mem_we = 0;
    armed_m = 0;
  endtask

  task automatic do_read(input logic [10:0] a, output logic [7:0] d, output logic v);
    @(negedge clk); mem_valid = 1; mem_we = 0; mem_addr = a;
    @(negedge clk); mem_valid = 0;
    d = mem_rdata; v = mem_rvalid;
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
    model_tick();
  endtask

  task automatic do_load(input int y, mo, md, wd, h, m, s);
    my = y; mmo = mo; mmd = md; mwd = wd; mh = h; mm = m; ms = s;
    @(negedge clk); tload_en = 1;
    tload_tod = {i2b(y), i2b(mo), i2b(md), i2b(wd), i2b(h), i2b(m), i2b(s)};
    @(negedge clk); tload_en = 0;
  endtask

  task automatic check_live(input string req);
    logic [7:0] d; logic v;
    for (int k = 1; k <= 7; k++) begin
      do_read(11'h7F8 + 11'(k), d, v);
      check(req, {24'd0, d}, {24'd0, exp_clk(k)});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, snap [8];
    logic v;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 armed", unlk_state, 32'd0);
    check("R1 rvalid", {31'd0, mem_rvalid}, 32'd0);
    check("R5 ready", {31'd0, mem_ready}, 32'd1);
    ms = 0; mm = 0; mh = 0; mwd = 1; mmd = 1; mmo = 1; my = 0;
    do_unlock(); do_write(11'h7F8, 8'h00);
    check_live("R1 R6 reset time");

    // R2 R3 R4 directed
    do_unlock();
    check("R2 armed", unlk_state, 32'd1);
    do_write(11'h010, 8'hA5);
    check("R3 cleared", unlk_state, 32'd0);
    do_write(11'h010, 8'h5A);
    do_read(11'h010, d, v);
    check("R3 single write", {24'd0, d}, 32'hA5);
    check("R5 rvalid", {31'd0, v}, 32'd1);
    model[16] = 8'hA5; known[16] = 1;
    // R12 same cycle
    @(negedge clk); unlk_wr = 1; mem_valid = 1; mem_we = 1; mem_addr = 11'h010; mem_wdata = 8'h77;
    @(negedge clk); unlk_wr = 0; mem_valid = 0; mem_we = 0;
    check("R12 armed after", unlk_state, 32'd1);
    do_read(11'h010, d, v);
    check("R12 write judged on old state", {24'd0, d}, 32'hA5);
    armed_m = 1;
    do_write(11'h010, 8'h77); model[16] = 8'h77;
    // R1 memory survives reset
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    ms = 0; mm = 0; mh = 0; mwd = 1; mmd = 1; mmo = 1; my = 0;
    check("R1 armed after reset", unlk_state, 32'd0);
    do_read(11'h010, d, v);
    check("R1 memory kept", {24'd0, d}, 32'h77);

    // R8 R9 R10 boundaries
    do_load(15, 2, 28, 7, 23, 59, 59); do_tick(); check_live("R10 R9 non-leap Feb");
    do_load(16, 2, 28, 3, 23, 59, 58); do_tick(); do_tick(); check_live("R10 leap Feb 29");
    do_load(16, 2, 29, 4, 23, 59, 59); do_tick(); check_live("R10 leap to Mar");
    do_load(0, 2, 28, 1, 23, 59, 59); do_tick(); check_live("R10 year 00 leap");
    do_load(21, 4, 30, 5, 23, 59, 59); do_tick(); check_live("R10 30-day month");
    do_load(99, 12, 31, 6, 23, 59, 59); do_tick(); check_live("R10 year wrap");
    do_load(42, 7, 14, 2, 9, 59, 59); do_tick(); check_live("R8 hour carry");
    do_load(42, 7, 14, 2, 19, 29, 59); do_tick(); check_live("R8 minute carry");
    // R11 load wins over tick
    @(negedge clk); tload_en = 1; tick = 1;
    tload_tod = {8'h33, 8'h08, 8'h15, 8'h05, 8'h12, 8'h34, 8'h56};
    @(negedge clk); tload_en = 0; tick = 0;
    my = 33; mmo = 8; mmd = 15; mwd = 5; mh = 12; mm = 34; ms = 56;
    check_live("R11 load priority");
    repeat (4) @(negedge clk);
    check_live("R11 hold");

    // R7 freeze
    do_unlock(); do_write(11'h7F8, 8'h40);
    for (int k = 1; k <= 7; k++) snap[k] = exp_clk(k);
    repeat (3) do_tick();
    for (int k = 1; k <= 7; k++) begin
      do_read(11'h7F8 + 11'(k), d, v);
      check("R7 snapshot", {24'd0, d}, {24'd0, snap[k]});
    end
    do_unlock(); do_write(11'h7FA, 8'h33);
    do_read(11'h7FA, d, v);
    check("R7 snapshot edit", {24'd0, d}, 32'h33);
    do_write(11'h7FB, 8'h11);
    do_read(11'h7FB, d, v);
    check("R4 clock byte locked", {24'd0, d}, {24'd0, snap[3]});
    do_read(11'h7F8, d, v);
    check("R5 ctrl byte", {24'd0, d}, 32'h40);
    do_unlock(); do_write(11'h7F8, 8'h00);
    check_live("R6 live again");

    // random memory traffic
    for (int i = 0; i < 400; i++) begin
      int a;
      a = $urandom_range(0, 63);
      if ($urandom_range(0, 1) == 1) do_unlock();
      if ($urandom_range(0, 2) != 0) begin
        logic [7:0] w;
        w = 8'($urandom);
        if (armed_m) begin model[a] = w; known[a] = 1; end
        do_write(11'(a), w);
      end else begin
        do_read(11'(a), d, v);
        if (known[a]) check("R3 R4 R5 random", {24'd0, d}, {24'd0, model[a]});
      end
    end

    // random times and tick runs
    for (int i = 0; i < 40; i++) begin
      int mo, y;
      y = $urandom_range(0, 99); mo = $urandom_range(1, 12);
      do_load(y, mo, $urandom_range(dim(mo, y) - 1, dim(mo, y)), $urandom_range(1, 7),
              $urandom_range(22, 23), $urandom_range(58, 59), $urandom_range(50, 59));
      repeat ($urandom_range(1, 80)) do_tick();
      check_live("R8 R9 R10 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule